// File: doc/BRIEF.md
# NOR Flash Command Sequencer

This block sits between a host that thinks in flash operations and a parallel NOR flash that only understands sequences of write cycles to particular addresses. The host gives one request: an opcode, a target address and a data word. The block turns it into a fixed script of write cycles. Most scripts start with a two-write unlock prefix, then carry the command code, and some end with the host's own address or data. The device side is a plain synchronous write port. The sequencer holds each write on it until the port acknowledges it, then moves on to the next write in the script.

Six operations are defined: return to read mode, identifier entry (autoselect), single-word program, sector erase, whole-chip erase and query-table entry. A mode input chooses between word-wide and byte-wide devices. In byte-wide mode every command address the block generates is doubled, while addresses supplied by the host pass through untouched. While a script runs the block reports busy and ignores new requests. Completion is marked by a one-cycle done pulse. An unknown opcode produces a one-cycle error pulse and no bus activity. Reading back identifier or query words, status polling and pin timing belong to other logic.

The controller has four states. IDLE waits for a request. ISSUE drives the current write and waits for the acknowledge. REPORT raises done for one cycle. REJECT raises err for one cycle. The transitions are named as follows:
- IDLE→ISSUE on a known opcode.
- IDLE→REJECT on an unknown opcode.
- ISSUE→ISSUE on an acknowledge of a write that is not the last, or while the acknowledge is absent.
- ISSUE→REPORT on the acknowledge of the last write.
- REPORT→IDLE and REJECT→IDLE unconditionally.

Top module: `nor_cmd_seq`

## Requirements
- R1: While reset is asserted and in the first cycle after it, busy, done, err and bus_we are all 0.
- R2: Opcode 2 (program) issues four writes in this order: 0xAA@0x555, 0x55@0x2AA, 0xA0@0x555, then the host data at the host address.
- R3: Opcode 4 (chip erase) issues six writes in this order: 0xAA@0x555, 0x55@0x2AA, 0x80@0x555, 0xAA@0x555, 0x55@0x2AA, 0x10@0x555.
- R4: Opcode 3 (sector erase) issues the first five writes of R3, then 0x30 at the host address.
- R5: Opcode 1 (identifier entry) issues 0xAA@0x555, 0x55@0x2AA, 0x90@0x555.
- R6: Opcode 5 (query entry) issues one write of 0x98@0x55 with no unlock prefix.
- R7: Opcode 0 (read reset) issues one write of 0xF0 at address 0.
- R8: When byte_mode is 1 at request time, every generated command address is shifted left by one bit (0x555→0xAAA, 0x2AA→0x554, 0x55→0xAA). Host addresses are never shifted.
- R9: busy is 1 from the cycle after a request is taken until the sequence ends. A request presented while busy is 1 is ignored and adds no write.
- R10: done is 1 for exactly one cycle: the cycle after the last write of a sequence is acknowledged.
- R11: Opcodes 6 and 7 give err=1 for exactly one cycle, in the cycle after the request, and no write is issued.
- R12: A write is held with bus_we=1 and unchanged bus_addr and bus_data until a cycle in which bus_ack is 1. The next write, if any, follows in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request strobe, taken when busy is 0 |
| req_op | input | 3 | Operation code (0 to 5 valid) |
| req_addr | input | ADDR_W | Host target address for program or sector erase |
| req_data | input | DATA_W | Host data word for program |
| byte_mode | input | 1 | 1 selects byte-wide command addressing |
| busy | output | 1 | Sequence or pulse in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle unknown-opcode pulse |
| bus_addr | output | ADDR_W | Device write address |
| bus_data | output | DATA_W | Device write data |
| bus_we | output | 1 | Device write request |
| bus_ack | input | 1 | Device accepts the current write |

## Verification
Counting from the cycle in which the request is sampled, the first write appears one cycle later. Each following write appears in the cycle after the acknowledge of the one before it. done rises one cycle after the last acknowledged write, and err rises one cycle after a rejected request. The scoreboard monitor samples at the falling edge. It pops an expected write only in a cycle showing bus_we and bus_ack together, and it checks done exactly one sampled cycle after the last pop. The acknowledge is also withheld for several cycles in some runs, to show that a stalled write stays unchanged.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;

    localparam int CMD_AW = 12;
    localparam int CMD_DW = 8;
    localparam int STEP_W = 3;

    typedef enum logic [2:0] {
        OP_READ_RESET   = 3'd0,
        OP_AUTOSELECT   = 3'd1,
        OP_WORD_PROG    = 3'd2,
        OP_SECTOR_ERASE = 3'd3,
        OP_CHIP_ERASE   = 3'd4,
        OP_QUERY        = 3'd5
    } nor_op_e;

    // One entry of a write script
    typedef struct packed {
        logic              addr_user;  // use host address, unshifted
        logic              data_user;  // use host data word
        logic [CMD_AW-1:0] cmd_addr;
        logic [CMD_DW-1:0] cmd_data;
        logic              last;
    } nor_step_t;

    function automatic logic op_known(input logic [2:0] op);
        return op <= 3'd5;
    endfunction

    function automatic nor_step_t mk_step(input logic [CMD_AW-1:0] a,
                                          input logic [CMD_DW-1:0] d,
                                          input logic au, input logic du,
                                          input logic lst);
        nor_step_t s;
        s.addr_user = au;
        s.data_user = du;
        s.cmd_addr  = a;
        s.cmd_data  = d;
        s.last      = lst;
        return s;
    endfunction

endpackage

// File: rtl/nor_seq_script.sv
module nor_seq_script
    import nor_seq_pkg::*;
(
    input  logic [2:0]        op,
    input  logic [STEP_W-1:0] step,
    output nor_step_t         entry
);

    localparam logic [CMD_AW-1:0] A_HI  = 12'h555;
    localparam logic [CMD_AW-1:0] A_LO  = 12'h2AA;
    localparam logic [CMD_AW-1:0] A_QRY = 12'h055;
    localparam logic [CMD_AW-1:0] A_NUL = 12'h000;

    nor_step_t unlock_e;
    nor_step_t erase_e;

    // Shared unlock prefix for step 0 and 1
    always_comb begin
        if (step[0] == 1'b0) unlock_e = mk_step(A_HI, 8'hAA, 1'b0, 1'b0, 1'b0);
        else                 unlock_e = mk_step(A_LO, 8'h55, 1'b0, 1'b0, 1'b0);
    end

    // Shared six-write erase script; step 5 depends on the variant
    always_comb begin
        unique case (step)
            3'd0, 3'd1: erase_e = unlock_e;
            3'd2:       erase_e = mk_step(A_HI, 8'h80, 1'b0, 1'b0, 1'b0);
            3'd3:       erase_e = mk_step(A_HI, 8'hAA, 1'b0, 1'b0, 1'b0);
            3'd4:       erase_e = mk_step(A_LO, 8'h55, 1'b0, 1'b0, 1'b0);
            default: begin
                if (op == OP_SECTOR_ERASE)
                    erase_e = mk_step(A_NUL, 8'h30, 1'b1, 1'b0, 1'b1);
                else
                    erase_e = mk_step(A_HI, 8'h10, 1'b0, 1'b0, 1'b1);
            end
        endcase
    end

    always_comb begin
        unique case (op)
            OP_READ_RESET: entry = mk_step(A_NUL, 8'hF0, 1'b0, 1'b0, 1'b1);
            OP_QUERY:      entry = mk_step(A_QRY, 8'h98, 1'b0, 1'b0, 1'b1);
            OP_AUTOSELECT: begin
                if (step < 3'd2) entry = unlock_e;
                else             entry = mk_step(A_HI, 8'h90, 1'b0, 1'b0, 1'b1);
            end
            OP_WORD_PROG: begin
                if (step < 3'd2)       entry = unlock_e;
                else if (step == 3'd2) entry = mk_step(A_HI, 8'hA0, 1'b0, 1'b0, 1'b0);
                else                   entry = mk_step(A_NUL, 8'h00, 1'b1, 1'b1, 1'b1);
            end
            OP_SECTOR_ERASE, OP_CHIP_ERASE: entry = erase_e;
            default: entry = mk_step(A_NUL, 8'h00, 1'b0, 1'b0, 1'b1);
        endcase
    end

endmodule

// File: rtl/nor_seq_addr_scale.sv
module nor_seq_addr_scale
    import nor_seq_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic [CMD_AW-1:0] cmd_addr,
    input  logic              addr_user,
    input  logic [ADDR_W-1:0] user_addr,
    input  logic              byte_mode,
    output logic [ADDR_W-1:0] bus_addr
);

    localparam int PAD_W = ADDR_W - CMD_AW;

    logic [ADDR_W-1:0] cmd_wide;

    generate
        if (PAD_W > 0) begin : g_pad
            assign cmd_wide = {{PAD_W{1'b0}}, cmd_addr};
        end else begin : g_trunc
            assign cmd_wide = cmd_addr[ADDR_W-1:0];
        end
    endgenerate

    always_comb begin
        if (addr_user)      bus_addr = user_addr;
        else if (byte_mode) bus_addr = cmd_wide << 1;
        else                bus_addr = cmd_wide;
    end

endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
    import nor_seq_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [2:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    input  logic              byte_mode,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_data,
    output logic              bus_we,
    input  logic              bus_ack
);

    localparam int DPAD_W = DATA_W - CMD_DW;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_REPORT,
        ST_REJECT
    } state_e;

    state_e            state_q, state_d;
    logic [2:0]        op_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    logic              mode_q;
    logic [STEP_W-1:0] step_q;
    nor_step_t         entry;
    logic [DATA_W-1:0] cmd_data_wide;

    nor_seq_script u_script (
        .op    (op_q),
        .step  (step_q),
        .entry (entry)
    );

    nor_seq_addr_scale #(.ADDR_W(ADDR_W)) u_scale (
        .cmd_addr  (entry.cmd_addr),
        .addr_user (entry.addr_user),
        .user_addr (addr_q),
        .byte_mode (mode_q),
        .bus_addr  (bus_addr)
    );

    generate
        if (DPAD_W > 0) begin : g_dpad
            assign cmd_data_wide = {{DPAD_W{1'b0}}, entry.cmd_data};
        end else begin : g_dtrunc
            assign cmd_data_wide = entry.cmd_data[DATA_W-1:0];
        end
    endgenerate

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) state_d = op_known(req_op) ? ST_ISSUE : ST_REJECT;
            end
            ST_ISSUE: begin
                if (bus_ack && entry.last) state_d = ST_REPORT;
            end
            ST_REPORT: state_d = ST_IDLE;
            ST_REJECT: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register and request capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            op_q    <= 3'd0;
            addr_q  <= '0;
            data_q  <= '0;
            mode_q  <= 1'b0;
            step_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && req_valid) begin
                op_q   <= req_op;
                addr_q <= req_addr;
                data_q <= req_data;
                mode_q <= byte_mode;
                step_q <= '0;
            end else if (state_q == ST_ISSUE && bus_ack && !entry.last) begin
                step_q <= step_q + 1'b1;
            end
        end
    end

    // Outputs
    always_comb begin
        busy     = (state_q != ST_IDLE);
        bus_we   = (state_q == ST_ISSUE);
        done     = (state_q == ST_REPORT);
        err      = (state_q == ST_REJECT);
        bus_data = entry.data_user ? data_q : cmd_data_wide;
    end

endmodule

// File: rtl/nor_cmd_seq_chk.sv
module nor_cmd_seq_chk #(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              busy,
    input logic              done,
    input logic              err,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_data,
    input logic              bus_we,
    input logic              bus_ack
);

    assert_hold_until_ack_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && !bus_ack) |=> (bus_we && $stable(bus_addr) && $stable(bus_data)));

    assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_after_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(bus_we && bus_ack));

    assert_err_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> !err);

    assert_err_no_bus_R11: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (!bus_we && $past(!bus_we && req_valid && !busy)));

    assert_we_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_we |-> busy);

    assert_pulse_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (done || err) |-> !bus_we);

endmodule

bind nor_cmd_seq nor_cmd_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .busy      (busy),
    .done      (done),
    .err       (err),
    .bus_addr  (bus_addr),
    .bus_data  (bus_data),
    .bus_we    (bus_we),
    .bus_ack   (bus_ack)
);

// File: tb/nor_cmd_seq_tb_top.sv
`timescale 1ns/1ps
module nor_cmd_seq_tb_top;

    localparam int AW = 24;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [2:0]    req_op = 3'd0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_data = '0;
    logic          byte_mode = 1'b0;
    logic          busy, done, err, bus_we;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_data;
    logic          bus_ack = 1'b0;

    typedef struct {
        logic [AW-1:0] a;
        logic [DW-1:0] d;
        logic          last;
        string         tag;
    } exp_t;

    exp_t q[$];
    int   n_checks = 0;
    int   n_fail = 0;
    int   ack_div = 1;
    bit   done_due = 1'b0;
    bit   finished = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    nor_cmd_seq #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_data(req_data), .byte_mode(byte_mode),
        .busy(busy), .done(done), .err(err), .bus_addr(bus_addr),
        .bus_data(bus_data), .bus_we(bus_we), .bus_ack(bus_ack)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
        end
    endtask

    // Acknowledge generator: changes just after the rising edge
    initial begin
        int cnt = 0;
        forever begin
            @(posedge clk);
            #1;
            cnt++;
            bus_ack = ((cnt % ack_div) == 0);
        end
    end

    // Monitor / scoreboard
    initial begin
        bit            stall_prev = 1'b0;
        logic [AW-1:0] pa = '0;
        logic [DW-1:0] pd = '0;
        forever begin
            @(negedge clk);
            if (rst_n && !finished) begin
                if (done_due) begin
                    check(done == 1'b1, "R10", "done after last ack", done, 1);
                    done_due = 1'b0;
                end else if (done) begin
                    check(1'b0, "R10", "unexpected done", done, 0);
                end
                if (stall_prev) begin
                    check(bus_we && bus_addr == pa && bus_data == pd, "R12",
                          "held write", {bus_we, bus_addr, bus_data}, {1'b1, pa, pd});
                end
                stall_prev = bus_we && !bus_ack;
                pa = bus_addr;
                pd = bus_data;
                if (bus_we && bus_ack) begin
                    if (q.size() == 0) begin
                        check(1'b0, "R9", "write with empty scoreboard", bus_addr, 0);
                    end else begin
                        exp_t e;
                        e = q.pop_front();
                        check(bus_addr == e.a && bus_data == e.d, e.tag, "write addr/data",
                              {bus_addr, bus_data}, {e.a, e.d});
                        if (e.last) done_due = 1'b1;
                    end
                end
            end
        end
    end

    task automatic push(input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input bit last, input string tag);
        exp_t e;
        e.a = a; e.d = d; e.last = last; e.tag = tag;
        q.push_back(e);
    endtask

    function automatic logic [AW-1:0] ca(input logic [AW-1:0] a, input bit m);
        return m ? (a << 1) : a;
    endfunction

    task automatic expect_op(input logic [2:0] op, input logic [AW-1:0] a,
                             input logic [DW-1:0] d, input bit m, input string tag);
        case (op)
            3'd0: push(24'h0, 16'h00F0, 1, tag);
            3'd5: push(ca(24'h55, m), 16'h0098, 1, tag);
            default: begin
                push(ca(24'h555, m), 16'h00AA, 0, tag);
                push(ca(24'h2AA, m), 16'h0055, 0, tag);
                if (op == 3'd1) push(ca(24'h555, m), 16'h0090, 1, tag);
                if (op == 3'd2) begin
                    push(ca(24'h555, m), 16'h00A0, 0, tag);
                    push(a, d, 1, tag);
                end
                if (op == 3'd3 || op == 3'd4) begin
                    push(ca(24'h555, m), 16'h0080, 0, tag);
                    push(ca(24'h555, m), 16'h00AA, 0, tag);
                    push(ca(24'h2AA, m), 16'h0055, 0, tag);
                    if (op == 3'd3) push(a, 16'h0030, 1, tag);
                    else            push(ca(24'h555, m), 16'h0010, 1, tag);
                end
            end
        endcase
    endtask

    task automatic send(input logic [2:0] op, input logic [AW-1:0] a,
                        input logic [DW-1:0] d, input bit m);
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_addr = a; req_data = d; byte_mode = m;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
        check(q.size() == 0, "R9", "scoreboard drained", q.size(), 0);
    endtask

    task automatic run_op(input logic [2:0] op, input logic [AW-1:0] a,
                          input logic [DW-1:0] d, input bit m, input string tag);
        expect_op(op, a, d, m, tag);
        send(op, a, d, m);
        check(busy == 1'b1, "R9", "busy after request", busy, 1);
        wait_idle();
    endtask

    task automatic run_bad(input logic [2:0] op);
        send(op, 24'h123, 16'hBEEF, 0);
        check(err == 1'b1 && bus_we == 1'b0, "R11", "err pulse, no write",
              {err, bus_we}, 2'b10);
        @(negedge clk);
        check(err == 1'b0 && busy == 1'b0, "R11", "err single cycle", {err, busy}, 0);
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=hung expected=finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(!busy && !done && !err && !bus_we, "R1", "outputs in reset",
              {busy, done, err, bus_we}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done && !err && !bus_we, "R1", "outputs after reset",
              {busy, done, err, bus_we}, 0);

        // Word mode, acknowledge every cycle
        run_op(3'd2, 24'h01_2340, 16'hC3A5, 0, "R2");
        run_op(3'd4, 24'h0,       16'h0,    0, "R3");
        run_op(3'd3, 24'h04_0000, 16'h0,    0, "R4");
        run_op(3'd1, 24'h0,       16'h0,    0, "R5");
        run_op(3'd5, 24'h0,       16'h0,    0, "R6");
        run_op(3'd0, 24'h7_7777,  16'h1111, 0, "R7");

        // Byte mode: command addresses doubled, host address unchanged
        run_op(3'd2, 24'h00_0AAB, 16'h5A5A, 1, "R8");
        run_op(3'd3, 24'h12_3457, 16'h0,    1, "R8");
        run_op(3'd5, 24'h0,       16'h0,    1, "R8");
        run_op(3'd0, 24'h0,       16'h0,    1, "R8");

        // Stalled acknowledges
        ack_div = 3;
        run_op(3'd4, 24'h0,       16'h0,    0, "R12");
        run_op(3'd2, 24'h00_FFFE, 16'hFFFF, 1, "R12");

        // Request during a sequence is ignored
        expect_op(3'd4, 24'h0, 16'h0, 0, "R9");
        send(3'd4, 24'h0, 16'h0, 0);
        check(busy == 1'b1, "R9", "busy mid-sequence", busy, 1);
        req_valid = 1'b1; req_op = 3'd2; req_addr = 24'h55_5555; req_data = 16'hDEAD;
        @(negedge clk);
        req_valid = 1'b0;
        wait_idle();
        ack_div = 1;

        // Undefined opcodes
        run_bad(3'd6);
        run_bad(3'd7);

        // Normal operation still works afterwards
        run_op(3'd1, 24'h0, 16'h0, 1, "R5");
        repeat (3) @(negedge clk);
        check(q.size() == 0 && !busy, "R11", "no stray writes", q.size(), 0);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule